// File: doc/BRIEF.md
# Synthesizer Divider and Channel Control

This block is the digital half of a phase-locked frequency synthesizer. A fixed divider brings a crystal clock down to the comparison rate, and a fixed prescaler followed by a programmable divider brings the oscillator feedback down to the same rate. A digital phase-frequency detector compares the two divided streams and issues pump-up and pump-down pulses to an external charge pump and loop filter, which steer the oscillator until the two divided frequencies agree.

The programmable ratio comes from a small channel table. Software loads the table once at setup through a plain write port. A channel-change request then copies the selected entry into the divider. With the default ratios (crystal divided by 1536, oscillator divided by 64), a 3 MHz crystal gives a 1953.125 Hz comparison rate, and a stored ratio of 5366 locks the oscillator at 670.75 MHz.

Both source clocks enter as single-cycle enable pulses on the block's system clock. Each asserted `ref_en` or `fb_en` counts as one source edge.

Top module: `synth_divctl`

## Requirements
- R1: `ref_div_o` pulses high for one cycle, one cycle after the enable that completes every REF_DIV-th `ref_en` pulse. Cycles with `ref_en` low advance nothing.
- R2: `fb_div_o` pulses high for one cycle once every PRE_DIV × N `fb_en` pulses, where N is the active programmable ratio.
- R3: The table holds CHAN_N entries of RATIO_W bits. A cycle with `wr_en` high writes `wr_ratio` to entry `wr_addr`. A cycle with `chan_chg` high selects entry `chan_sel` as the pending ratio.
- R4: A ratio written below PROG_MIN is stored as PROG_MIN.
- R5: A ratio written above PROG_MAX is stored as PROG_MAX.
- R6: A pending ratio becomes active only at the next terminal count of the programmable divider. The feedback period in progress when `chan_chg` arrives completes with the old ratio, and the following period uses the new one.
- R7: A table write with no `chan_chg` leaves the active and pending ratios unchanged, even when it writes the entry last selected.
- R8: `pump_up` rises in the cycle after a `ref_div_o` pulse and stays high until the pair-clear.
- R9: `pump_dn` rises in the cycle after a `fb_div_o` pulse and stays high until the pair-clear.
- R10: When `pump_up` and `pump_dn` are both high, both are low in the next cycle, unless a new divided edge arrives in that same cycle.
- R11: After reset, all outputs are low, every table entry holds PROG_MIN, and the active and pending ratios are PROG_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One pulse per crystal edge |
| fb_en | input | 1 | One pulse per oscillator edge |
| chan_sel | input | 6 | Channel to select on a change request |
| chan_chg | input | 1 | Channel-change request |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Table entry to write |
| wr_ratio | input | 13 | Ratio to write (clamped) |
| pump_up | output | 1 | Phase detector up pulse |
| pump_dn | output | 1 | Phase detector down pulse |
| ref_div_o | output | 1 | Divided reference pulse (debug) |
| fb_div_o | output | 1 | Divided feedback pulse (debug) |

## Verification
A corrupted ratio register or a wrongly clamped table entry shows up as a wrong spacing between `fb_div_o` pulses. That error is visible within one feedback period after the next terminal count, so the bench measures successive periods against queued expectations. A ratio that is swapped mid-period shows as one period with a mixed length right after a change request. A detector flip-flop that fails to set or clear shows at `pump_up`/`pump_dn` one cycle after the divided edge or the coincidence.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    // Default division settings of the synthesizer
    localparam int unsigned DEF_REF_DIV  = 1536;
    localparam int unsigned DEF_PRE_DIV  = 64;
    localparam int unsigned DEF_PROG_MIN = 256;
    localparam int unsigned DEF_PROG_MAX = 8191;
    localparam int unsigned DEF_CHAN_N   = 64;
    localparam int unsigned DEF_RATIO_W  = 13;

    // Phase detector state pair
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int unsigned DIV = 1536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } rdiv_t;

    rdiv_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (en) begin
            if (st_q.cnt == CW'(DIV - 1)) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    AST_REF_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en)); // R1
    AST_REF_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R1

endmodule

// File: rtl/synth_chan_tbl.sv
module synth_chan_tbl #(
    parameter int unsigned CHAN_N   = 64,
    parameter int unsigned RATIO_W  = 13,
    parameter int unsigned PROG_MIN = 256,
    parameter int unsigned PROG_MAX = 8191
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(CHAN_N)-1:0]     wr_addr,
    input  logic [RATIO_W-1:0]            wr_ratio,
    input  logic [$clog2(CHAN_N)-1:0]     rd_addr,
    output logic [RATIO_W-1:0]            rd_ratio
);
    localparam int unsigned AW = $clog2(CHAN_N);
    localparam logic [RATIO_W-1:0] LO = RATIO_W'(PROG_MIN);
    localparam logic [RATIO_W-1:0] HI = RATIO_W'(PROG_MAX);

    logic [RATIO_W-1:0] wr_fit;
    logic [RATIO_W-1:0] ent_all [CHAN_N];

    // Clamp the incoming ratio once, shared by all entries
    always_comb begin
        if (wr_ratio < LO)      wr_fit = LO;
        else if (wr_ratio > HI) wr_fit = HI;
        else                    wr_fit = wr_ratio;
    end

    for (genvar e = 0; e < CHAN_N; e++) begin : g_ent
        logic [RATIO_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_addr == AW'(e))) ent_d = wr_fit;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= LO;
            else        ent_q <= ent_d;
        end

        assign ent_all[e] = ent_q;

        AST_ENTRY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_q >= LO) && (ent_q <= HI)); // R4 R5
    end

    assign rd_ratio = ent_all[rd_addr];

endmodule

// File: rtl/synth_fb_div.sv
module synth_fb_div #(
    parameter int unsigned PRE_DIV  = 64,
    parameter int unsigned RATIO_W  = 13,
    parameter int unsigned PROG_MIN = 256,
    parameter int unsigned PROG_MAX = 8191
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               load_vld,
    input  logic [RATIO_W-1:0] load_ratio,
    output logic               tick_o
);
    localparam int unsigned PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [RATIO_W-1:0] LO = RATIO_W'(PROG_MIN);
    localparam logic [RATIO_W-1:0] HI = RATIO_W'(PROG_MAX);

    typedef struct packed {
        logic [PW-1:0]      pre;
        logic [RATIO_W-1:0] pc;
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] pend;
        logic               tick;
    } fdiv_t;

    fdiv_t st_d, st_q;
    logic  pre_wrap;
    logic  term;

    assign pre_wrap = en && (st_q.pre == PW'(PRE_DIV - 1));
    assign term     = pre_wrap && (st_q.pc == (st_q.ratio - 1'b1));

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (load_vld) st_d.pend = load_ratio;
        if (en) begin
            st_d.pre = pre_wrap ? '0 : st_q.pre + 1'b1;
        end
        if (pre_wrap) begin
            if (term) begin
                st_d.pc    = '0;
                st_d.tick  = 1'b1;
                st_d.ratio = load_vld ? load_ratio : st_q.pend;
            end else begin
                st_d.pc = st_q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ratio <= LO;
            st_q.pend  <= LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    AST_RATIO_ONLY_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(term) |-> $stable(st_q.ratio)); // R6
    AST_RATIO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ratio >= LO) && (st_q.ratio <= HI)); // R4 R5
    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_vld) |-> $stable(st_q.pend)); // R7
    AST_FB_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en)); // R2

endmodule

// File: rtl/synth_pfd.sv
module synth_pfd
    import synth_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic up_o,
    output logic dn_o
);
    pump_t st_d, st_q;
    logic  pair;

    assign pair = st_q.up && st_q.dn;

    always_comb begin
        st_d.up = ref_tick || (st_q.up && !pair);
        st_d.dn = fb_tick  || (st_q.dn && !pair);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o = st_q.up;
    assign dn_o = st_q.dn;

    AST_UP_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> up_o); // R8
    AST_DN_ON_FB: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |=> dn_o); // R9
    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && !dn_o) |=> up_o); // R8
    AST_DN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_o && !up_o) |=> dn_o); // R9
    AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && dn_o && !ref_tick && !fb_tick) |=> (!up_o && !dn_o)); // R10

endmodule

// File: rtl/synth_divctl.sv
module synth_divctl
    import synth_div_pkg::*;
#(
    parameter int unsigned REF_DIV  = DEF_REF_DIV,
    parameter int unsigned PRE_DIV  = DEF_PRE_DIV,
    parameter int unsigned PROG_MIN = DEF_PROG_MIN,
    parameter int unsigned PROG_MAX = DEF_PROG_MAX,
    parameter int unsigned CHAN_N   = DEF_CHAN_N,
    parameter int unsigned RATIO_W  = DEF_RATIO_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_en,
    input  logic                      fb_en,
    input  logic [$clog2(CHAN_N)-1:0] chan_sel,
    input  logic                      chan_chg,
    input  logic                      wr_en,
    input  logic [$clog2(CHAN_N)-1:0] wr_addr,
    input  logic [RATIO_W-1:0]        wr_ratio,
    output logic                      pump_up,
    output logic                      pump_dn,
    output logic                      ref_div_o,
    output logic                      fb_div_o
);
    logic [RATIO_W-1:0] sel_ratio;
    logic               ref_tick;
    logic               fb_tick;

    synth_ref_div #(.DIV(REF_DIV)) i_ref_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ref_en),
        .tick_o (ref_tick)
    );

    synth_chan_tbl #(
        .CHAN_N   (CHAN_N),
        .RATIO_W  (RATIO_W),
        .PROG_MIN (PROG_MIN),
        .PROG_MAX (PROG_MAX)
    ) i_chan_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_ratio (wr_ratio),
        .rd_addr  (chan_sel),
        .rd_ratio (sel_ratio)
    );

    synth_fb_div #(
        .PRE_DIV  (PRE_DIV),
        .RATIO_W  (RATIO_W),
        .PROG_MIN (PROG_MIN),
        .PROG_MAX (PROG_MAX)
    ) i_fb_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (fb_en),
        .load_vld   (chan_chg),
        .load_ratio (sel_ratio),
        .tick_o     (fb_tick)
    );

    synth_pfd i_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .fb_tick  (fb_tick),
        .up_o     (pump_up),
        .dn_o     (pump_dn)
    );

    assign ref_div_o = ref_tick;
    assign fb_div_o  = fb_tick;

endmodule

// File: tb/test_synth_divctl.sv
module test_synth_divctl;
    localparam int CLK_PERIOD = 10;
    localparam int REF_DIV  = 6;
    localparam int PRE_DIV  = 2;
    localparam int PROG_MIN = 4;
    localparam int PROG_MAX = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0, fb_en = 1'b0;
    logic [5:0]  chan_sel = '0;
    logic        chan_chg = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [12:0] wr_ratio = '0;
    logic        pump_up, pump_dn, ref_div_o, fb_div_o;

    int tests = 0, fails = 0;
    int cyc = 0;
    int exp_q[$];
    int last_fb = 0;
    bit have_last = 0;
    bit prev_pair = 0, prev_tick = 0;
    bit done = 0;

    synth_divctl #(
        .REF_DIV(REF_DIV), .PRE_DIV(PRE_DIV),
        .PROG_MIN(PROG_MIN), .PROG_MAX(PROG_MAX),
        .CHAN_N(64), .RATIO_W(13)
    ) i_synth_divctl (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .fb_en(fb_en),
        .chan_sel(chan_sel), .chan_chg(chan_chg),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_ratio(wr_ratio),
        .pump_up(pump_up), .pump_dn(pump_dn),
        .ref_div_o(ref_div_o), .fb_div_o(fb_div_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Monitor: feedback period scoreboard and detector pair-clear
    always @(negedge clk) begin
        if (!rst_n) begin
            have_last = 0;
            prev_pair = 0;
        end else begin
            if (fb_div_o) begin
                if (have_last && exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc - last_fb == e, "R2/R6 fb period", cyc - last_fb, e);
                end
                last_fb   = cyc;
                have_last = 1;
            end
            if (prev_pair && !prev_tick)
                check(!pump_up && !pump_dn, "R10 pair clear", {pump_up, pump_dn}, 0);
            prev_pair = pump_up && pump_dn;
            prev_tick = ref_div_o || fb_div_o;
        end
    end

    task automatic wait_fb();
        do @(negedge clk); while (!fb_div_o);
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() > 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic measure(input int exp, input int n);
        wait_fb();
        @(negedge clk);
        repeat (n) exp_q.push_back(exp);
        drain();
    endtask

    task automatic write_ent(input int a, input int r);
        @(negedge clk);
        wr_en = 1; wr_addr = 6'(a); wr_ratio = 13'(r);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic select(input int ch);
        @(negedge clk);
        chan_sel = 6'(ch); chan_chg = 1;
        @(negedge clk);
        chan_chg = 0;
        wait_fb();
        wait_fb();
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int t0, nref;
        // R11 reset state
        do_reset();
        @(negedge clk);
        check(!pump_up && !pump_dn && !ref_div_o && !fb_div_o, "R11 outputs after reset",
              {pump_up, pump_dn, ref_div_o, fb_div_o}, 0);
        // R1 no counting without ref_en
        nref = 0;
        repeat (20) begin @(negedge clk); if (ref_div_o) nref++; end
        check(nref == 0, "R1 gated reference", nref, 0);
        // R11 reset ratio is PROG_MIN, R2 period PRE*N
        fb_en = 1;
        measure(PRE_DIV * PROG_MIN, 2);
        // R3 program and select channels; R4/R5 clamp
        write_ent(3, 10);
        write_ent(5, 1);
        write_ent(6, 100);
        write_ent(7, 20);
        select(3);  measure(PRE_DIV * 10, 2);        // R3
        select(5);  measure(PRE_DIV * PROG_MIN, 2);  // R4
        select(6);  measure(PRE_DIV * PROG_MAX, 2);  // R5
        // R7 write without change leaves ratio alone
        write_ent(6, 10);
        measure(PRE_DIV * PROG_MAX, 2);
        select(6);  measure(PRE_DIV * 10, 2);        // R7 reload after change
        // R6 change mid-period: current period old, next new
        select(3);
        wait_fb();
        @(negedge clk);
        exp_q.push_back(PRE_DIV * 10);
        exp_q.push_back(PRE_DIV * 20);
        repeat (5) @(negedge clk);
        chan_sel = 6'd7; chan_chg = 1;
        @(negedge clk);
        chan_chg = 0;
        drain();
        // R1 reference period
        ref_en = 1;
        do @(negedge clk); while (!ref_div_o);
        t0 = cyc;
        @(negedge clk);
        check(!ref_div_o, "R1 single-cycle pulse", ref_div_o, 0);
        do @(negedge clk); while (!ref_div_o);
        check(cyc - t0 == REF_DIV, "R1 reference period", cyc - t0, REF_DIV);
        // Phase detector directed
        fb_en = 0; ref_en = 0;
        do_reset();
        ref_en = 1;
        do @(negedge clk); while (!ref_div_o);
        check(!pump_up, "R8 up not yet", pump_up, 0);
        ref_en = 0;
        @(negedge clk);
        check(pump_up && !pump_dn, "R8 up after ref edge", {pump_up, pump_dn}, 2);
        repeat (30) @(negedge clk);
        check(pump_up && !pump_dn, "R8 up held", {pump_up, pump_dn}, 2);
        fb_en = 1;
        wait_fb();
        @(negedge clk);
        check(pump_up && pump_dn, "R10 both set", {pump_up, pump_dn}, 3);
        @(negedge clk);
        check(!pump_up && !pump_dn, "R10 both cleared", {pump_up, pump_dn}, 0);
        wait_fb();
        fb_en = 0;
        @(negedge clk);
        check(pump_dn && !pump_up, "R9 dn after fb edge", {pump_up, pump_dn}, 1);
        repeat (20) @(negedge clk);
        check(pump_dn && !pump_up, "R9 dn held", {pump_up, pump_dn}, 1);
        ref_en = 1;
        do @(negedge clk); while (!ref_div_o);
        ref_en = 0;
        @(negedge clk);
        check(pump_up && pump_dn, "R10 both set on ref", {pump_up, pump_dn}, 3);
        @(negedge clk);
        check(!pump_up && !pump_dn, "R10 cleared again", {pump_up, pump_dn}, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule